// File: doc/BRIEF.md
# Key-Armed Configuration Write Gate

This block holds one 32-bit lock register inside an 8-byte register window. All pin groups share it, and it decides whether their pin-mode configuration registers may be written. Software arms the gate by writing one specific 16-bit key into the low half of the register. It closes the gate again by writing zero there. Any other key value leaves the gate as it was.

The armed state drives `cfg_wr_allow`, a qualifier that the mode registers of every pin group AND into their own write strobes. A read of the lock register returns the armed flag in the top bit and the last key written in the low half. Arming and disarming take effect on the clock edge that accepts the write, so the new state is visible from the next cycle.

Top module: `cfg_key_lock`

## Requirements
- R1: After reset the gate is disarmed, the stored key field is 0x0000, `cfg_wr_allow` is 0, and a read of the lock word returns 0x00000000.
- R2: An accepted write whose bits 15:0 equal 0xD42F arms the gate, whatever the upper write-data bits hold. `cfg_wr_allow` is 1 from the cycle after the write.
- R3: An accepted write whose bits 15:0 equal 0x0000 disarms the gate. `cfg_wr_allow` is 0 from the cycle after the write.
- R4: An accepted write with any other value in bits 15:0 leaves the armed state unchanged.
- R5: In a read of the lock word, bit 31 is 1 while the gate is armed and 0 otherwise, and bits 30:16 are always 0.
- R6: In a read of the lock word, bits 15:0 return bits 15:0 of the most recent accepted write, whatever the key value.
- R7: A write is accepted only when `bus_sel` and `bus_wr` are both 1 and `bus_addr[2]` is 0, which selects the lock word. A write to the upper word of the window (`bus_addr[2]` = 1) or with `bus_sel` low changes nothing. `bus_rdata` is 0 when `bus_sel` is low or when the upper word is addressed.
- R8: `cfg_wr_allow` equals the armed state at all times. Mode-register writes are permitted exactly while the gate is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register window selected |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset within the 8-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cfg_wr_allow | output | 1 | Write-enable qualifier for the mode registers |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 16-bit key field and an arming key of 0xD42F. With these values the arming key, the zero key and the other key values can all be driven directly. A random phase weights the arming key and zero heavily, so that the gate toggles often. The same phase also mixes in writes to the upper word, deselected writes and non-zero upper write-data bits. On every cycle, a behavioural model in the bench predicts the read word and the qualifier.

// File: rtl/cfg_key_lock.sv
module cfg_key_lock #(
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 16,
  parameter int ADDR_W  = 3,
  parameter logic [KEY_W-1:0] ARM_KEY = 16'hD42F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_wr_allow
);
  localparam int PAD_W = DATA_W - 1 - KEY_W;

  logic             armed_q;
  logic [KEY_W-1:0] key_q;
  logic             word0;
  logic             wr_acc;
  logic [KEY_W-1:0] wkey;
  logic             sig_unused;

  assign word0  = ~bus_addr[ADDR_W-1];
  assign wr_acc = bus_sel & bus_wr & word0;
  assign wkey   = bus_wdata[KEY_W-1:0];
  assign sig_unused = ^{bus_addr[ADDR_W-2:0], bus_wdata[DATA_W-1:KEY_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      key_q   <= '0;
    end else if (wr_acc) begin
      key_q <= wkey;
      if (wkey == ARM_KEY)   armed_q <= 1'b1;
      else if (wkey == '0)   armed_q <= 1'b0;
    end
  end

  assign bus_rdata    = (bus_sel && word0) ? {armed_q, {PAD_W{1'b0}}, key_q} : '0;
  assign cfg_wr_allow = armed_q;

  a_r2_arm_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr[ADDR_W-1] && bus_wdata[KEY_W-1:0] == ARM_KEY)
      |=> cfg_wr_allow);

  a_r3_zero_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr[ADDR_W-1] && bus_wdata[KEY_W-1:0] == '0)
      |=> !cfg_wr_allow);

  a_r4_other_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr[ADDR_W-1] &&
     bus_wdata[KEY_W-1:0] != ARM_KEY && bus_wdata[KEY_W-1:0] != '0)
      |=> $stable(cfg_wr_allow));

  a_r7_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && !bus_addr[ADDR_W-1])
      |=> ($stable(cfg_wr_allow) && $stable(key_q)));

  a_r6_key_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr[ADDR_W-1])
      |=> key_q == $past(bus_wdata[KEY_W-1:0]));

  always_comb begin
    if (rst_n) begin
      a_r5_pad_zero: assert (bus_rdata[DATA_W-2:KEY_W] == '0);
      a_r8_status_bit: assert (!(bus_sel && !bus_addr[ADDR_W-1]) ||
                               bus_rdata[DATA_W-1] == cfg_wr_allow);
    end
  end
endmodule

// File: tb/cfg_key_lock_tb.sv
module cfg_key_lock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_wr_allow;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_armed = 1'b0;
  logic [15:0] m_key = '0;

  cfg_key_lock u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_rd();
    if (bus_sel && !bus_addr[2]) return {m_armed, 15'b0, m_key};
    return 32'h0;
  endfunction

  task automatic compare(string tag);
    n_cmp++;
    if (bus_rdata !== exp_rd() || cfg_wr_allow !== m_armed) begin
      n_bad++;
      $display("FAIL %s rdata=%h exp=%h allow=%b exp=%b", tag,
               bus_rdata, exp_rd(), cfg_wr_allow, m_armed);
    end
  endtask

  task automatic step(bit sel, bit wr, logic [2:0] addr, logic [31:0] d, string tag);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = d;
    #1 compare(tag);
    @(posedge clk);
    if (sel && wr && !addr[2]) begin
      m_key = d[15:0];
      if (d[15:0] == 16'hD42F) m_armed = 1'b1;
      else if (d[15:0] == 16'h0) m_armed = 1'b0;
    end
  endtask

  task automatic rd(string tag);
    step(1'b1, 1'b0, 3'd0, 32'h0, tag);
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rd("R1 reset state");
    @(negedge clk) rst_n = 1'b1;
    rd("R1 after reset release");
    step(1, 1, 3'd0, 32'h0000_D42F, "R2 arm write");
    rd("R2 R5 R8 armed readback");
    step(1, 1, 3'd0, 32'h0000_1234, "R4 other key");
    rd("R4 R6 still armed, key 1234");
    step(1, 1, 3'd0, 32'h0000_0000, "R3 disarm write");
    rd("R3 disarmed");
    step(1, 1, 3'd0, 32'h0000_D42E, "R4 near key");
    rd("R4 stays disarmed");
    step(1, 1, 3'd0, 32'hFFFF_D42F, "R2 arm with upper bits");
    rd("R2 R5 upper bits dropped");
    step(1, 1, 3'd4, 32'h0000_0000, "R7 upper word write");
    step(1, 0, 3'd4, 32'h0, "R7 upper word reads zero");
    rd("R7 still armed");
    step(0, 1, 3'd0, 32'h0000_0000, "R7 deselected write");
    rd("R7 R8 still armed");
    step(1, 1, 3'd3, 32'h0000_0000, "R7 low offset bits ignored");
    rd("R3 disarmed via offset 3");
    for (int i = 0; i < 3000; i++) begin
      int sel_k = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      if (sel_k < 3) d[15:0] = 16'hD42F;
      else if (sel_k < 6) d[15:0] = 16'h0;
      step(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
           3'($urandom_range(0, 7)), d, "R2 R3 R4 R5 R6 R7 R8 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule